// File: doc/BRIEF.md
# Fault Header Register with Selective Clear-on-Read

This block keeps the eight-bit fault header that a serial slave shifts out at the start of every transaction. It receives five live fault conditions from the detection logic, one live low-power-mode status flag, a configuration bit that picks sticky or live behaviour, and a read event from the serial interface. The read event says which register the host read and whether that transaction had a framing or checksum error. The block drives the registered header byte and a combined fault flag.

In sticky mode a fault bit stays set once its condition has been seen. It drops only when two things are true: the host has read the register tied to that bit, and the condition has gone away. A read inside a transaction that had an error clears nothing. In live mode every fault bit follows its condition. The low-power-mode bit is always live. The two top bits are reserved and always read as 0.

A change on an input appears on the outputs two clock edges after it is sampled. The first edge loads the per-bit state and the second loads the output register. A qualifying read clears the state on the edge at which it is sampled, so the header shows the cleared bit one edge later.

Top module: `fault_hdr_latch`

## Requirements
- R1: While `rst` is high at a clock edge, `hdr_byte` and `fault_any` become 0 after that edge.
- R2: With `rt_mode` = 0, an input `fault_in[i]` that is high at one edge sets its header bit. The bit is visible after the next edge and stays 1 after the input drops. The header positions are: `fault_in[0]` global error/warning to bit 0, `fault_in[1]` open-load/short/supply-off to bit 1, `fault_in[2]` overcurrent/thermal to bit 2, `fault_in[3]` channel-1 fault to bit 4, and `fault_in[4]` channel-2 fault to bit 5.
- R3: With `rt_mode` = 0, a read event (`rd_evt` = 1, `rd_err` = 0) clears the channel-2 bit when `rd_sel` = 2'b10, and clears the channel-1 bit when `rd_sel` = 2'b01. A bit is cleared only if its fault input is low.
- R4: With `rt_mode` = 0, header bits 2 and 1 clear on a read with `rd_sel` = 2'b01 or 2'b10. Bit 0 clears only on a read with `rd_sel` = 2'b11 (the global fault register).
- R5: A read with `rd_err` = 1, or a read with `rd_sel` = 2'b00 (any other register), leaves every latched bit unchanged.
- R6: When a fault input is high in the same cycle as a read that would clear its bit, the bit stays 1.
- R7: With `rt_mode` = 1, each fault header bit equals its fault input as sampled two edges earlier, whatever reads occur.
- R8: Header bit 3 equals `lpm_in` as sampled two edges earlier, in both modes.
- R9: Header bits 7 and 6 are always 0.
- R10: `fault_any` is 1 exactly when some bit of `hdr_byte` is 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_mode | input | 1 | 0 = sticky fault bits, 1 = live fault bits |
| fault_in | input | 5 | Live fault conditions (see R2 for positions) |
| lpm_in | input | 1 | Live low-power-mode status |
| rd_evt | input | 1 | One-cycle strobe marking the end of a register read |
| rd_sel | input | 2 | Register read: 00 other, 01 channel-1 fault, 10 channel-2 fault, 11 global fault |
| rd_err | input | 1 | The read transaction had a framing or checksum error |
| hdr_byte | output | 8 | Registered fault header byte |
| fault_any | output | 1 | Registered OR of the header bits |

## Verification
Wrong per-bit state shows on `hdr_byte` one edge after the state register loads it. A clear that is decoded for the wrong register makes a bit drop after a read that should not touch it, or stay high after the read that should clear it, one edge after the read. If the error qualification is lost, bits disappear after an errored read. A broken set-over-clear priority loses a fault that was reported in the same cycle as the read. A mode bypass that goes wrong makes the live bits lag or stick across the following cycles. A wrong combined flag disagrees with the header in the same cycle.

// File: rtl/fault_hdr_pkg.sv
package fault_hdr_pkg;

  localparam int NUM_FLT = 5;
  localparam int HDR_W   = 8;
  localparam int SEL_W   = 2;
  localparam int NUM_SEL = 1 << SEL_W;
  localparam int LPM_POS = 3;

  typedef enum logic [SEL_W-1:0] {
    RD_OTHER  = 2'b00,
    RD_CH1    = 2'b01,
    RD_CH2    = 2'b10,
    RD_GLOBAL = 2'b11
  } rd_sel_e;

  // Header position of each fault input.
  function automatic int hdr_pos(input int idx);
    case (idx)
      0: hdr_pos = 0;
      1: hdr_pos = 1;
      2: hdr_pos = 2;
      3: hdr_pos = 4;
      default: hdr_pos = 5;
    endcase
  endfunction

  // Register selects (one bit per select code) whose read clears a fault.
  function automatic logic [NUM_SEL-1:0] clr_src(input int idx);
    logic [NUM_SEL-1:0] m;
    m = '0;
    case (idx)
      0: m[RD_GLOBAL] = 1'b1;
      1, 2: begin
        m[RD_CH1] = 1'b1;
        m[RD_CH2] = 1'b1;
      end
      3: m[RD_CH1] = 1'b1;
      default: m[RD_CH2] = 1'b1;
    endcase
    clr_src = m;
  endfunction

endpackage

// File: rtl/fault_hdr_clr_decode.sv
module fault_hdr_clr_decode
  import fault_hdr_pkg::*;
#(
  parameter int N = NUM_FLT
) (
  input  logic             rd_evt,
  input  logic [SEL_W-1:0] rd_sel,
  input  logic             rd_err,
  output logic [N-1:0]     clr_vec
);

  logic rd_ok;
  assign rd_ok = rd_evt & ~rd_err;

  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam logic [NUM_SEL-1:0] SRC = clr_src(i);
    assign clr_vec[i] = rd_ok & SRC[rd_sel];
  end

endmodule

// File: rtl/fault_hdr_cell.sv
module fault_hdr_cell #(
  parameter bit RT_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic rt_mode,
  input  logic flt,
  input  logic clr,
  output logic state_q
);

  logic live;
  assign live = RT_ONLY ? 1'b1 : rt_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= 1'b0;
    end else if (live) begin
      state_q <= flt;
    end else begin
      // A fault that is present wins over a clear in the same cycle.
      state_q <= flt | (state_q & ~clr);
    end
  end

endmodule

// File: rtl/fault_hdr_pack.sv
module fault_hdr_pack
  import fault_hdr_pkg::*;
#(
  parameter int N = NUM_FLT,
  parameter int W = HDR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lat,
  input  logic         lpm_q,
  output logic [W-1:0] hdr_q,
  output logic         any_q
);

  logic [W-1:0] hdr_d;

  always_comb begin
    hdr_d = '0;
    for (int i = 0; i < N; i++) begin
      hdr_d[hdr_pos(i)] = lat[i];
    end
    hdr_d[LPM_POS] = lpm_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q <= '0;
      any_q <= 1'b0;
    end else begin
      hdr_q <= hdr_d;
      any_q <= |hdr_d;
    end
  end

endmodule

// File: rtl/fault_hdr_latch.sv
module fault_hdr_latch
  import fault_hdr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               rt_mode,
  input  logic [NUM_FLT-1:0] fault_in,
  input  logic               lpm_in,
  input  logic               rd_evt,
  input  logic [SEL_W-1:0]   rd_sel,
  input  logic               rd_err,
  output logic [HDR_W-1:0]   hdr_byte,
  output logic               fault_any
);

  logic [NUM_FLT-1:0] clr_vec;
  logic [NUM_FLT-1:0] lat_q;
  logic               lpm_q;

  fault_hdr_clr_decode #(.N(NUM_FLT)) u_dec (
    .rd_evt  (rd_evt),
    .rd_sel  (rd_sel),
    .rd_err  (rd_err),
    .clr_vec (clr_vec)
  );

  for (genvar i = 0; i < NUM_FLT; i++) begin : g_cell
    fault_hdr_cell #(.RT_ONLY(1'b0)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .rt_mode (rt_mode),
      .flt     (fault_in[i]),
      .clr     (clr_vec[i]),
      .state_q (lat_q[i])
    );
  end

  fault_hdr_cell #(.RT_ONLY(1'b1)) u_lpm (
    .clk     (clk),
    .rst     (rst),
    .rt_mode (rt_mode),
    .flt     (lpm_in),
    .clr     (1'b0),
    .state_q (lpm_q)
  );

  fault_hdr_pack #(.N(NUM_FLT), .W(HDR_W)) u_pack (
    .clk   (clk),
    .rst   (rst),
    .lat   (lat_q),
    .lpm_q (lpm_q),
    .hdr_q (hdr_byte),
    .any_q (fault_any)
  );

endmodule

// File: rtl/fault_hdr_chk.sv
module fault_hdr_chk
  import fault_hdr_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               rt_mode,
  input logic [NUM_FLT-1:0] fault_in,
  input logic               lpm_in,
  input logic               rd_evt,
  input logic [SEL_W-1:0]   rd_sel,
  input logic               rd_err,
  input logic [HDR_W-1:0]   hdr_byte,
  input logic               fault_any,
  input logic [NUM_FLT-1:0] lat_q
);

  logic [1:0] up_cnt;
  logic       clr_try;

  always_ff @(posedge clk) begin
    if (rst) up_cnt <= 2'd0;
    else if (up_cnt != 2'd2) up_cnt <= up_cnt + 2'd1;
  end

  assign clr_try = rd_evt && !rd_err && (rd_sel != RD_OTHER);

  // R2
  fault_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_in != '0) |=> ((lat_q & $past(fault_in)) == $past(fault_in)));

  // R3
  ch2_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!rt_mode && rd_evt && !rd_err && rd_sel == RD_CH2 && !fault_in[4]) |=> !lat_q[4]);

  // R3
  ch1_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!rt_mode && rd_evt && !rd_err && rd_sel == RD_CH1 && !fault_in[3]) |=> !lat_q[3]);

  // R4
  glob_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!rt_mode && rd_evt && !rd_err && rd_sel == RD_GLOBAL && !fault_in[0]) |=> !lat_q[0]);

  // R5
  no_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!rt_mode && !clr_try) |=> ((lat_q & $past(lat_q)) == $past(lat_q)));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_try && fault_in != '0) |=> ((lat_q & $past(fault_in)) == $past(fault_in)));

  // R7
  live_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rt_mode |=> (lat_q == $past(fault_in)));

  // R8
  lpm_live_chk: assert property (@(posedge clk) disable iff (rst)
    (up_cnt == 2'd2) |-> (hdr_byte[LPM_POS] == $past(lpm_in, 2)));

  // R10
  any_flag_chk: assert property (@(posedge clk) disable iff (rst)
    fault_any == (hdr_byte != '0));

endmodule

bind fault_hdr_latch fault_hdr_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rt_mode   (rt_mode),
  .fault_in  (fault_in),
  .lpm_in    (lpm_in),
  .rd_evt    (rd_evt),
  .rd_sel    (rd_sel),
  .rd_err    (rd_err),
  .hdr_byte  (hdr_byte),
  .fault_any (fault_any),
  .lat_q     (lat_q)
);

// File: tb/fault_hdr_latch_test.sv
`timescale 1ns/1ps
module fault_hdr_latch_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rt_mode = 1'b0;
  logic [4:0] fault_in = '0;
  logic       lpm_in = 1'b0;
  logic       rd_evt = 1'b0;
  logic [1:0] rd_sel = 2'b00;
  logic       rd_err = 1'b0;
  logic [7:0] hdr_byte;
  logic       fault_any;

  int n_chk = 0;
  int n_bad = 0;

  logic [4:0] m_lat = '0;
  logic       m_lpm = 1'b0;
  logic [7:0] m_hdr = '0;

  always #2.5 clk = ~clk;

  fault_hdr_latch uut (
    .clk(clk), .rst(rst), .rt_mode(rt_mode), .fault_in(fault_in),
    .lpm_in(lpm_in), .rd_evt(rd_evt), .rd_sel(rd_sel), .rd_err(rd_err),
    .hdr_byte(hdr_byte), .fault_any(fault_any)
  );

  // Header layout from R2, R8, R9.
  function automatic logic [7:0] pack(input logic [4:0] f, input logic l);
    return {2'b00, f[4], f[3], l, f[2], f[1], f[0]};
  endfunction

  // Clear sources from R3, R4, R5.
  function automatic logic [4:0] clear_of(input logic ev, input logic er, input logic [1:0] s);
    if (!ev || er) return 5'b00000;
    case (s)
      2'b01:   return 5'b01110;
      2'b10:   return 5'b10110;
      2'b11:   return 5'b00001;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input string req);
    @(posedge clk);
    #1;
    if (rst) begin
      m_lat = '0; m_lpm = 1'b0; m_hdr = '0;
    end else begin
      m_hdr = pack(m_lat, m_lpm);
      if (rt_mode) m_lat = fault_in;
      else m_lat = fault_in | (m_lat & ~clear_of(rd_evt, rd_err, rd_sel));
      m_lpm = lpm_in;
    end
    @(negedge clk);
    check(req, hdr_byte, m_hdr);
    check("R10", {7'd0, fault_any}, {7'd0, (hdr_byte != 8'h00)});
    check("R9", {6'd0, hdr_byte[7:6]}, 8'h00);
  endtask

  task automatic rd(input logic [1:0] s, input logic e, input string req);
    rd_evt = 1'b1; rd_sel = s; rd_err = e;
    step(req);
    rd_evt = 1'b0; rd_sel = 2'b00; rd_err = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    @(negedge clk);
    step("R1"); step("R1");
    rst = 1'b0;
    check("R1", hdr_byte, 8'h00);
    check("R1", {7'd0, fault_any}, 8'h00);

    // R2: one-cycle pulse on every fault, bits stay set
    fault_in = 5'b11111; step("R2");
    fault_in = 5'b00000; step("R2");
    check("R2", hdr_byte, 8'h37);
    step("R2"); step("R2");
    check("R2", hdr_byte, 8'h37);

    // R5: other-register read and errored read clear nothing
    rd(2'b00, 1'b0, "R5"); step("R5");
    check("R5", hdr_byte, 8'h37);
    rd(2'b10, 1'b1, "R5"); step("R5");
    check("R5", hdr_byte, 8'h37);
    rd(2'b11, 1'b1, "R5"); step("R5");
    check("R5", hdr_byte, 8'h37);

    // R3/R4: channel-2 read clears ch2, ocp, open-load
    rd(2'b10, 1'b0, "R3"); step("R3");
    check("R3", hdr_byte, 8'h11);

    // R3: channel-1 read
    fault_in = 5'b11111; step("R3");
    fault_in = 5'b00000;
    rd(2'b01, 1'b0, "R3"); step("R3");
    check("R3", hdr_byte, 8'h21);

    // R4: global read clears bit 0 only
    rd(2'b11, 1'b0, "R4"); step("R4");
    check("R4", hdr_byte, 8'h20);

    // R6: fault present during the clearing read
    fault_in = 5'b10000;
    rd(2'b10, 1'b0, "R6");
    fault_in = 5'b00000; step("R6");
    check("R6", hdr_byte, 8'h20);
    rd(2'b10, 1'b0, "R6"); step("R6");
    check("R6", hdr_byte, 8'h00);

    // R8: low-power status is live in both modes
    lpm_in = 1'b1; step("R8"); step("R8");
    check("R8", hdr_byte, 8'h08);
    lpm_in = 1'b0; step("R8");
    check("R8", hdr_byte, 8'h08);
    step("R8");
    check("R8", hdr_byte, 8'h00);

    // R7: live mode follows inputs
    rt_mode = 1'b1;
    fault_in = 5'b00011; lpm_in = 1'b1; step("R7"); step("R7");
    check("R7", hdr_byte, 8'h0b);
    fault_in = 5'b00000; lpm_in = 1'b0; step("R7");
    check("R7", hdr_byte, 8'h0b);
    rd(2'b11, 1'b0, "R7");
    check("R7", hdr_byte, 8'h00);

    // Random mix of modes, faults and reads against the model (R2 R3 R4 R5 R6 R7 R8)
    rt_mode = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      if (($urandom % 64) == 0) rt_mode = ~rt_mode;
      for (int b = 0; b < 5; b++) begin
        if (($urandom % 8) == 0) fault_in[b] = ~fault_in[b];
      end
      if (($urandom % 16) == 0) lpm_in = ~lpm_in;
      rd_evt = (($urandom % 4) == 0);
      rd_sel = 2'($urandom);
      rd_err = (($urandom % 5) == 0);
      step("R2 R3 R4 R5 R6 R7 R8 random");
    end
    rd_evt = 1'b0;

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule